// File: doc/BRIEF.md
# Programmed-I/O Buffer Transfer Engine

This block lets a host processor reach a local packet buffer RAM one port access at a time. Through a byte-wide register window the host sets a 16-bit buffer address and a 16-bit byte count, picks byte or word width, and then writes a command that starts a read or a write transfer. Each access to the separate 16-bit data port then moves one byte (byte mode) or two bytes (word mode), with the address and count stepping on their own. When the count runs out the transfer ends and a completion flag appears in a status register, which the host clears by writing a one to it.

A read transfer fetches ahead, so the first data-port read after the start command already carries valid data and each read fetches the next location. A pair of page registers (256-byte units) bounds the buffer: an address that steps onto the upper page boundary wraps to the lower one. The host can cancel a transfer at any time with an abort command, and after reset the command and status registers hold a fixed signature that probe software can recognise.

Top module: `rdma_engine`

## Requirements
- R1: After reset the command register (offset 0) reads 0x21, the status register (offset 1) reads 0x80, the config register (offset 2) reads 0x00, the lower page register (offset 7) reads 0x00 and the upper page register (offset 8) reads RAM_BYTES/256.
- R2: Status bit 7 is the reset flag and bit 6 the transfer-done flag; writing the status register clears exactly the bits written as one and leaves the others.
- R3: The address is loaded through offsets 3 (low byte) and 4 (high byte), the count through offsets 5 (low) and 6 (high), and both read back their current values; a transfer starts when the command is written with bit 1 set and bits 5:3 equal to 001 (read) or 010 (write).
- R4: When an access brings the count to zero the transfer ends, status bit 6 sets and command bits 5:3 read back 100; a start with a count of zero ends at once in the same way without moving the address.
- R5: In a read transfer the first data-port read returns the data at the start address in that same access, and each further read returns the next location.
- R6: Config bit 0 set selects word mode: each access moves bits 7:0 at the even address and bits 15:8 at the next one, and the count drops by two; with an odd remainder the final access moves both bytes and the count ends at zero.
- R7: When the stepped address lands in the page held in offset 8, it becomes the lower page (offset 7) times 256.
- R8: A command with bit 5 set ends a running transfer at once without setting status bit 6, and the count register then shows the bytes not yet moved.
- R9: While no transfer runs, data-port writes leave the buffer unchanged and data-port reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 4 | Register offset for host register access |
| regWr | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for the offset on regSel |
| portWr | input | 1 | Data-port write strobe |
| portRd | input | 1 | Data-port read strobe |
| portWrData | input | 16 | Data-port write data |
| portRdData | output | 16 | Data-port read data |

## Verification
A wrong address or count shows up on the very next data-port read as a mismatching byte, or in the address and count registers read back right after the last access. A lost or early end of transfer shows in the status and command registers immediately after the access that should have ended it, and a lane swap in word mode shows when the same bytes are read back one at a time. Random transfers of mixed width and alignment are compared against a byte model of the buffer, alongside directed wrap, abort, zero-count and odd-remainder cases.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [3:0] {
    REG_CMD     = 4'd0,
    REG_STAT    = 4'd1,
    REG_CFG     = 4'd2,
    REG_ADDR_LO = 4'd3,
    REG_ADDR_HI = 4'd4,
    REG_CNT_LO  = 4'd5,
    REG_CNT_HI  = 4'd6,
    REG_PG_LO   = 4'd7,
    REG_PG_HI   = 4'd8
  } reg_sel_e;

  localparam int CMD_STOP  = 0;
  localparam int CMD_START = 1;
  localparam int STAT_DONE = 6;
  localparam int STAT_RST  = 7;

  localparam logic [2:0] OP_READ  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_IDLE  = 3'b100;

  typedef struct packed {
    logic       ldAddrLo;
    logic       ldAddrHi;
    logic       ldCntLo;
    logic       ldCntHi;
    logic       prefetch;
    logic       stepWr;
    logic       stepRd;
    logic       wordMode;
    logic       rdValid;
    logic [7:0] hostByte;
  } dp_ctl_t;

endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int RAM_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regSel,
  input  logic        regWr,
  input  logic [7:0]  wrData,
  input  logic        portWr,
  input  logic        portRd,
  input  logic [15:0] curAddr,
  input  logic [15:0] curCnt,
  input  logic        lastStep,
  output logic [7:0]  rdData,
  output dp_ctl_t     ctl,
  output logic [7:0]  pgLo,
  output logic [7:0]  pgHi,
  output logic        xferActive,
  output logic        xferWrite,
  output logic        doneFlag
);

  localparam logic [7:0] PG_HI_RST = 8'(RAM_BYTES / 256);
  localparam logic [7:0] CMD_RST   = 8'h21;
  localparam logic [7:0] STAT_RSTV = 8'h80;

  logic [7:0] cmdQ, statQ, statNext;
  logic       cfgWordQ;
  logic       activeQ, dirWrQ;
  logic       cmdWr, statWr, startReq, abortReq, cntZero;
  logic       stepWr, stepRd, finish, setDone;

  assign cmdWr    = regWr && (regSel == REG_CMD);
  assign statWr   = regWr && (regSel == REG_STAT);
  assign startReq = cmdWr && wrData[CMD_START] &&
                    ((wrData[5:3] == OP_READ) || (wrData[5:3] == OP_WRITE));
  assign abortReq = cmdWr && wrData[5];
  assign cntZero  = (curCnt == 16'h0000);

  assign stepWr  = activeQ && dirWrQ && portWr && !cmdWr;
  assign stepRd  = activeQ && !dirWrQ && portRd && !cmdWr;
  assign finish  = (stepWr || stepRd) && lastStep;
  assign setDone = finish || (startReq && cntZero);

  always_comb begin
    statNext = statQ;
    if (statWr) statNext = statNext & ~wrData;
    if (setDone) statNext[STAT_DONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ     <= CMD_RST;
      statQ    <= STAT_RSTV;
      cfgWordQ <= 1'b0;
      pgLo     <= 8'h00;
      pgHi     <= PG_HI_RST;
      activeQ  <= 1'b0;
      dirWrQ   <= 1'b0;
    end else begin
      statQ <= statNext;
      if (regWr && regSel == REG_CFG)   cfgWordQ <= wrData[0];
      if (regWr && regSel == REG_PG_LO) pgLo     <= wrData;
      if (regWr && regSel == REG_PG_HI) pgHi     <= wrData;
      if (cmdWr) begin
        if (startReq && cntZero) begin
          cmdQ    <= {wrData[7:6], OP_IDLE, wrData[2:0]};
          activeQ <= 1'b0;
        end else begin
          cmdQ <= wrData;
          if (startReq) begin
            activeQ <= 1'b1;
            dirWrQ  <= wrData[4];
          end else if (abortReq) begin
            activeQ <= 1'b0;
          end
        end
      end else if (finish) begin
        cmdQ[5:3] <= OP_IDLE;
        activeQ   <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regSel)
      REG_CMD:     rdData = cmdQ;
      REG_STAT:    rdData = statQ;
      REG_CFG:     rdData = {7'b0, cfgWordQ};
      REG_ADDR_LO: rdData = curAddr[7:0];
      REG_ADDR_HI: rdData = curAddr[15:8];
      REG_CNT_LO:  rdData = curCnt[7:0];
      REG_CNT_HI:  rdData = curCnt[15:8];
      REG_PG_LO:   rdData = pgLo;
      REG_PG_HI:   rdData = pgHi;
      default:     rdData = 8'h00;
    endcase
  end

  always_comb begin
    ctl.ldAddrLo = regWr && (regSel == REG_ADDR_LO);
    ctl.ldAddrHi = regWr && (regSel == REG_ADDR_HI);
    ctl.ldCntLo  = regWr && (regSel == REG_CNT_LO);
    ctl.ldCntHi  = regWr && (regSel == REG_CNT_HI);
    ctl.prefetch = startReq && !cntZero && (wrData[5:3] == OP_READ);
    ctl.stepWr   = stepWr;
    ctl.stepRd   = stepRd;
    ctl.wordMode = cfgWordQ;
    ctl.rdValid  = activeQ && !dirWrQ;
    ctl.hostByte = wrData;
  end

  assign xferActive = activeQ;
  assign xferWrite  = dirWrQ;
  assign doneFlag   = statQ[STAT_DONE];

endmodule

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int RAM_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  dp_ctl_t     ctl,
  input  logic [7:0]  pgLo,
  input  logic [7:0]  pgHi,
  input  logic [15:0] portWrData,
  output logic [15:0] portRdData,
  output logic [15:0] curAddr,
  output logic [15:0] curCnt,
  output logic        lastStep
);

  localparam int BANK_DEPTH = RAM_BYTES / 2;
  localparam int BW         = $clog2(BANK_DEPTH);

  logic [15:0] addrQ, cntQ, fetchQ;
  logic [15:0] stepSize, sumAddr, nextAddr;
  logic [7:0]  curByte [2];
  logic [7:0]  nxtByte [2];
  logic [15:0] curWord, nxtWord;

  assign stepSize = ctl.wordMode ? 16'd2 : 16'd1;
  assign sumAddr  = addrQ + stepSize;
  assign nextAddr = (sumAddr[15:8] == pgHi) ? {pgLo, 8'h00} : sumAddr;
  assign lastStep = (cntQ <= stepSize);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [BANK_DEPTH];
    logic       bankWe;
    logic [7:0] bankDin;
    assign bankWe  = ctl.stepWr && (ctl.wordMode || (addrQ[0] == (b != 0)));
    assign bankDin = (ctl.wordMode && (b != 0)) ? portWrData[15:8] : portWrData[7:0];
    always_ff @(posedge clk) begin
      if (bankWe) mem[addrQ[BW:1]] <= bankDin;
    end
    assign curByte[b] = mem[addrQ[BW:1]];
    assign nxtByte[b] = mem[nextAddr[BW:1]];
  end

  assign curWord = ctl.wordMode ? {curByte[1], curByte[0]}
                                : {8'h00, (addrQ[0] ? curByte[1] : curByte[0])};
  assign nxtWord = ctl.wordMode ? {nxtByte[1], nxtByte[0]}
                                : {8'h00, (nextAddr[0] ? nxtByte[1] : nxtByte[0])};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= 16'h0000;
      cntQ   <= 16'h0000;
      fetchQ <= 16'h0000;
    end else begin
      if (ctl.ldAddrLo)      addrQ[7:0]  <= ctl.hostByte;
      else if (ctl.ldAddrHi) addrQ[15:8] <= ctl.hostByte;
      else if (ctl.stepWr || ctl.stepRd) addrQ <= nextAddr;

      if (ctl.ldCntLo)      cntQ[7:0]  <= ctl.hostByte;
      else if (ctl.ldCntHi) cntQ[15:8] <= ctl.hostByte;
      else if (ctl.stepWr || ctl.stepRd) cntQ <= lastStep ? 16'h0000 : cntQ - stepSize;

      if (ctl.prefetch)    fetchQ <= curWord;
      else if (ctl.stepRd) fetchQ <= nxtWord;
    end
  end

  assign portRdData = ctl.rdValid ? fetchQ : 16'h0000;
  assign curAddr    = addrQ;
  assign curCnt     = cntQ;

endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int RAM_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regSel,
  input  logic        regWr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        portWr,
  input  logic        portRd,
  input  logic [15:0] portWrData,
  output logic [15:0] portRdData
);

  dp_ctl_t     ctl;
  logic [7:0]  pgLo, pgHi;
  logic [15:0] curAddr, curCnt;
  logic        lastStep, xferActive, xferWrite, doneFlag, wordMode;

  rdma_ctrl #(.RAM_BYTES(RAM_BYTES)) i_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .wrData(wrData),
    .portWr(portWr), .portRd(portRd), .curAddr(curAddr), .curCnt(curCnt),
    .lastStep(lastStep), .rdData(rdData), .ctl(ctl), .pgLo(pgLo), .pgHi(pgHi),
    .xferActive(xferActive), .xferWrite(xferWrite), .doneFlag(doneFlag)
  );

  rdma_datapath #(.RAM_BYTES(RAM_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pgLo(pgLo), .pgHi(pgHi),
    .portWrData(portWrData), .portRdData(portRdData), .curAddr(curAddr),
    .curCnt(curCnt), .lastStep(lastStep)
  );

  assign wordMode = ctl.wordMode;

endmodule

// File: rtl/rdma_checker.sv
module rdma_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic [3:0]  regSel,
  input logic [7:0]  wrData,
  input logic        portWr,
  input logic        portRd,
  input logic [15:0] portRdData,
  input logic        xferActive,
  input logic        xferWrite,
  input logic        wordMode,
  input logic [15:0] curCnt,
  input logic        doneFlag
);

  // R4: the done flag only rises after a port access or a command
  a_r4_done_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(portWr || portRd || regWr));

  // R9: no read data leaves the port unless a read transfer runs
  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive || xferWrite) |-> (portRdData == 16'h0000));

  // R6: a word write access lowers the count by two
  a_r6_word_step: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && xferWrite && portWr && wordMode && !regWr && curCnt >= 16'd2)
      |=> (curCnt == $past(curCnt) - 16'd2));

  // R8: an abort command stops the transfer without a done flag
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == 4'd0 && wrData[5])
      |=> (!xferActive && doneFlag == $past(doneFlag)));

  // R3: the count never grows while a transfer runs unless the host loads it
  a_r3_count_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && !(regWr && (regSel == 4'd5 || regSel == 4'd6)))
      |=> (curCnt <= $past(curCnt)));

endmodule

bind rdma_engine rdma_checker i_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .wrData(wrData),
  .portWr(portWr), .portRd(portRd), .portRdData(portRdData),
  .xferActive(xferActive), .xferWrite(xferWrite), .wordMode(wordMode),
  .curCnt(curCnt), .doneFlag(doneFlag)
);

// File: tb/test_rdma_engine.sv
module test_rdma_engine;

  localparam int RAM_BYTES = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regSel = 4'd0;
  logic        regWr = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic        portWr = 1'b0;
  logic        portRd = 1'b0;
  logic [15:0] portWrData = 16'h0000;
  logic [15:0] portRdData;

  int errs = 0;
  int total = 0;
  logic [7:0] model [RAM_BYTES];
  logic [7:0] pgS = 8'h00;
  logic [7:0] pgE = 8'h04;

  rdma_engine #(.RAM_BYTES(RAM_BYTES)) i_rdma_engine (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .wrData(wrData),
    .rdData(rdData), .portWr(portWr), .portRd(portRd),
    .portWrData(portWrData), .portRdData(portRdData)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stepAddr(input logic [15:0] a, input int step);
    logic [15:0] n;
    n = a + 16'(step);
    if (n[15:8] == pgE) n = {pgS, 8'h00};
    return n;
  endfunction

  task automatic regW(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; wrData = d; regWr = 1'b1;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic regR(input logic [3:0] sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = rdData;
  endtask

  task automatic portW(input logic [15:0] d);
    @(negedge clk);
    portWrData = d; portWr = 1'b1;
    @(posedge clk); #1;
    portWr = 1'b0;
  endtask

  task automatic portR(output logic [15:0] d);
    @(negedge clk);
    portRd = 1'b1;
    #1 d = portRdData;
    @(posedge clk); #1;
    portRd = 1'b0;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] n, input bit word, input bit isWr);
    regW(4'd2, {7'b0, word});
    regW(4'd3, a[7:0]);
    regW(4'd4, a[15:8]);
    regW(4'd5, n[7:0]);
    regW(4'd6, n[15:8]);
    regW(4'd0, isWr ? 8'h12 : 8'h0A);
  endtask

  task automatic checkAddrCnt(input string req, input logic [15:0] ea, input logic [15:0] ec);
    logic [7:0] lo, hi;
    regR(4'd3, lo); regR(4'd4, hi);
    check(req, {hi, lo}, ea);
    regR(4'd5, lo); regR(4'd6, hi);
    check(req, {hi, lo}, ec);
  endtask

  task automatic clearStat();
    regW(4'd1, 8'hFF);
  endtask

  // write n bytes of random data starting at a, updating the model
  task automatic writeXfer(input logic [15:0] a, input int n, input bit word);
    logic [15:0] cur, d;
    int left;
    cur = a; left = n;
    setup(a, 16'(n), word, 1'b1);
    while (left > 0) begin
      d = 16'($urandom);
      portW(d);
      if (word) begin
        model[cur[9:0]] = d[7:0];
        model[cur[9:0] + 10'd1] = d[15:8];
        cur = stepAddr(cur, 2); left -= 2;
      end else begin
        model[cur[9:0]] = d[7:0];
        cur = stepAddr(cur, 1); left -= 1;
      end
    end
  endtask

  task automatic readXfer(input string req, input logic [15:0] a, input int n, input bit word);
    logic [15:0] cur, d, e;
    logic [7:0]  s;
    int left;
    cur = a; left = n;
    setup(a, 16'(n), word, 1'b0);
    while (left > 0) begin
      portR(d);
      e = word ? {model[cur[9:0] + 10'd1], model[cur[9:0]]} : {8'h00, model[cur[9:0]]};
      check(req, d, e);
      cur = stepAddr(cur, word ? 2 : 1);
      left -= word ? 2 : 1;
    end
    regR(4'd1, s);
    check("R4 read done flag", s, 8'h40);
    clearStat();
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] d;
    void'($urandom(32'h1357));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset signature
    regR(4'd0, v); check("R1 cmd", v, 8'h21);
    regR(4'd1, v); check("R1 status", v, 8'h80);
    regR(4'd2, v); check("R1 config", v, 8'h00);
    regR(4'd7, v); check("R1 page lo", v, 8'h00);
    regR(4'd8, v); check("R1 page hi", v, 8'h04);

    // R9 idle read
    portR(d); check("R9 idle read", d, 16'h0000);

    // R3 R4 byte write of 16 bytes
    writeXfer(16'h0050, 16, 1'b0);
    regR(4'd1, v); check("R4 done with reset flag", v, 8'hC0);
    regR(4'd0, v); check("R4 cmd idles", v, 8'h22);
    checkAddrCnt("R3 addr/count after write", 16'h0060, 16'h0000);

    // R2 selective clear
    regW(4'd1, 8'h40); regR(4'd1, v); check("R2 clear done only", v, 8'h80);
    regW(4'd1, 8'h80); regR(4'd1, v); check("R2 clear reset flag", v, 8'h00);

    // R5 read back with prefetch
    readXfer("R5 byte readback", 16'h0050, 16, 1'b0);

    // R8 abort mid-transfer
    setup(16'h0050, 16'd10, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      d = 16'($urandom);
      portW(d);
      model[10'h050 + 10'(i)] = d[7:0];
    end
    regW(4'd0, 8'h20);
    checkAddrCnt("R8 remaining count", 16'h0053, 16'd7);
    regR(4'd1, v); check("R8 no done flag", v, 8'h00);
    // R9 ignored accesses after abort
    portW(16'h00EE);
    portR(d); check("R9 read after abort", d, 16'h0000);
    checkAddrCnt("R9 no step when idle", 16'h0053, 16'd7);
    readXfer("R9 buffer untouched", 16'h0050, 16, 1'b0);

    // R4 zero count start
    setup(16'h0123, 16'd0, 1'b0, 1'b1);
    regR(4'd1, v); check("R4 zero count done", v, 8'h40);
    regR(4'd0, v); check("R4 zero count cmd", v, 8'h22);
    checkAddrCnt("R4 zero count addr", 16'h0123, 16'd0);
    clearStat();

    // R6 word mode with odd count
    setup(16'h0080, 16'd5, 1'b1, 1'b1);
    portW(16'hB1A0); portW(16'hB3A2);
    regR(4'd1, v); check("R6 not done early", v, 8'h00);
    checkAddrCnt("R6 count by two", 16'h0084, 16'd1);
    portW(16'hB5A4);
    regR(4'd1, v); check("R6 odd remainder done", v, 8'h40);
    checkAddrCnt("R6 final count", 16'h0086, 16'd0);
    clearStat();
    model[10'h080] = 8'hA0; model[10'h081] = 8'hB1;
    model[10'h082] = 8'hA2; model[10'h083] = 8'hB3;
    model[10'h084] = 8'hA4; model[10'h085] = 8'hB5;
    readXfer("R6 lane order", 16'h0080, 6, 1'b0);
    readXfer("R6 word readback", 16'h0080, 6, 1'b1);

    // R7 wrap between pages 1 and 2
    regW(4'd7, 8'h01); regW(4'd8, 8'h02); pgS = 8'h01; pgE = 8'h02;
    writeXfer(16'h01FC, 8, 1'b0);
    checkAddrCnt("R7 byte wrap addr", 16'h0104, 16'd0);
    clearStat();
    readXfer("R7 byte wrap read", 16'h01FC, 8, 1'b0);
    writeXfer(16'h01FE, 4, 1'b1);
    checkAddrCnt("R7 word wrap addr", 16'h0102, 16'd0);
    clearStat();
    readXfer("R7 word wrap read", 16'h01FE, 4, 1'b1);
    regW(4'd7, 8'h00); regW(4'd8, 8'h04); pgS = 8'h00; pgE = 8'h04;

    // random mixed transfers
    for (int it = 0; it < 24; it++) begin
      logic [15:0] a;
      int n;
      bit w, rw;
      w = 1'($urandom);
      a = 16'($urandom % 32'h3E0);
      n = 1 + int'($urandom % 32);
      if (w) begin a[0] = 1'b0; n = n + (n % 2); end
      writeXfer(a, n, w);
      regR(4'd1, v); check("R4 random write done", v, 8'h40);
      clearStat();
      rw = (a[0] == 1'b0 && (n % 2) == 0) ? 1'($urandom) : 1'b0;
      readXfer(w ? "R6 random readback" : "R5 random readback", a, n, rw);
    end

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule